// File: doc/BRIEF.md
# Remote Processor Start Controller

This block is the start path between a controlling processor and a coupled processor that it supervises. The controlling side executes a start instruction. While the pair is coupled (multiprocess mode), the instruction's operand sets a bank of qualifier triggers that the remote processor sees: a basic start, a skip request and a transfer request. A third operand bit enables traps from the controller to the remote. Outside multiprocess mode the instruction does nothing except take its usual execution time.

The remote side holds its program counter and the reason it last halted. The halt can be a plain halt, a halt-and-transfer, or a divide-check halt. When a start trigger is present and the remote's mode switch is in automatic, the block clears master stop. It then computes the resume address from the halt cause and the qualifiers, and raises a one-cycle instruction-cycle strobe. That strobe, or an instruction-cycle signal from a remote that is already running, clears the qualifier triggers. A start sent to a running remote changes nothing on the remote.

Top module: `rps_top`

## Requirements
- R1: After reset, the remote is halted with `pc_o` = 0. `busy_o`, `done_o`, all three triggers, `trap_en_o`, `running_o` and `icycle_o` are 0.
- R2: A start accepted while `mp_mode_i` is 0 sets no trigger and leaves `trap_en_o` unchanged. A halted remote stays halted with its `pc_o` unchanged.
- R3: The operand field is decoded as follows: `opnd_i[0]` requests a skip, `opnd_i[1]` requests a transfer and `opnd_i[2]` enables traps. An accepted start in multiprocess mode always sets the start trigger and loads the skip and transfer triggers from those bits.
- R4: The halt cause is encoded as 00 plain, 01 halt-and-transfer, 10 divide-check and 11 reserved. Without qualifiers, a remote halted by code 01 resumes at the latched address field. Any other code resumes at the halting location plus one, modulo 2^AW.
- R5: A skip request adds one more increment in the same restart cycle, giving the halting location plus two. A skip request has no effect when the halt cause is 01.
- R6: A transfer request overrides skip and the halt cause. The remote resumes at `XFER_ADDR` (default 4).
- R7: For a start accepted at clock edge E0 to a halted remote in automatic, the following sequence applies. `halted_o` falls after E1. `pc_o` takes the resume address and `icycle_o` rises after E2. `icycle_o` is high for exactly one cycle, and `running_o` rises after E3.
- R8: The triggers clear on the edge that ends a cycle in which `icycle_o` or `remote_icyc_i` is high. A start accepted in that same cycle takes precedence over the clear.
- R9: While `auto_i` is 0, a halted remote does not restart and its triggers stay set. The remote restarts when `auto_i` later goes to 1.
- R10: A start sent to a running remote leaves `pc_o` and `running_o` unchanged. Its trap-enable bit still takes effect.
- R11: Every start instruction holds `busy_o` for exactly `EXEC_CYC` cycles (default 3), with or without multiprocess mode. `done_o` is high in the last of those cycles. A `start_i` pulse that arrives while `busy_o` is high is ignored.
- R12: Once set, `trap_en_o` remains set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start instruction strobe from the controlling side |
| opnd_i | input | OPW | Qualifier field of the start operand |
| mp_mode_i | input | 1 | Multiprocess mode level |
| halt_req_i | input | 1 | Remote executes a halting instruction this cycle |
| halt_cause_i | input | 2 | Kind of halting instruction |
| halt_loc_i | input | AW | Location of the halting instruction |
| halt_field_i | input | AW | Address field of the halting instruction |
| auto_i | input | 1 | Remote mode switch: 1 automatic, 0 manual |
| remote_icyc_i | input | 1 | Instruction-cycle signal of a running remote |
| busy_o | output | 1 | Start instruction executing |
| done_o | output | 1 | Last execution cycle of the start instruction |
| start_trg_o | output | 1 | Start trigger |
| skip_trg_o | output | 1 | Skip qualifier trigger |
| xfer_trg_o | output | 1 | Transfer qualifier trigger |
| trap_en_o | output | 1 | Traps from controller to remote enabled |
| halted_o | output | 1 | Remote in master stop |
| running_o | output | 1 | Remote running |
| icycle_o | output | 1 | Restart instruction-cycle strobe |
| pc_o | output | AW | Remote program counter |

## Verification
The resume address is tested against every halt cause, both with and without skip and transfer qualifiers. This shows that transfer dominates both skip and the halt cause, and that skip is dropped only for halt-and-transfer. Halting locations at the top of the address space show that the one-step and two-step increments wrap. Separate directed patterns cover the following cases: a start outside multiprocess mode, a start in manual that is later switched to automatic, a start to a running remote, and a second strobe during execution. These cases separate "no effect" from "deferred effect" and from "side effect only". A cycle-by-cycle trace of one restart pins down the latency of each output.

// File: rtl/rps_pkg.sv
package rps_pkg;
   typedef enum logic [1:0] {
      CAUSE_PLAIN  = 2'b00,
      CAUSE_HTR    = 2'b01,
      CAUSE_DIVCHK = 2'b10,
      CAUSE_RSVD   = 2'b11
   } halt_cause_e;

   typedef enum logic [1:0] {
      RS_RUN,
      RS_HALT,
      RS_RESTART,
      RS_ICYC
   } rstate_e;

   localparam int unsigned NTRIG    = 3;
   localparam int unsigned TG_START = 0;
   localparam int unsigned TG_SKIP  = 1;
   localparam int unsigned TG_XFER  = 2;
endpackage

// File: rtl/rps_opdec.sv
module rps_opdec #(
   parameter int unsigned OPW      = 3,
   parameter int unsigned SKIP_BIT = 0,
   parameter int unsigned XFER_BIT = 1,
   parameter int unsigned TRAP_BIT = 2
) (
   input  logic [OPW-1:0] opnd_i,
   output logic           skip_o,
   output logic           xfer_o,
   output logic           trap_o
);
   generate
      if (SKIP_BIT >= OPW || XFER_BIT >= OPW || TRAP_BIT >= OPW) begin : g_bad_pos
         $error("rps_opdec: qualifier bit outside operand field");
      end
      if (SKIP_BIT == XFER_BIT || SKIP_BIT == TRAP_BIT || XFER_BIT == TRAP_BIT) begin : g_bad_dup
         $error("rps_opdec: qualifier bits must be distinct");
      end
   endgenerate

   assign skip_o = opnd_i[SKIP_BIT];
   assign xfer_o = opnd_i[XFER_BIT];
   assign trap_o = opnd_i[TRAP_BIT];
endmodule

// File: rtl/rps_exec_tmr.sv
module rps_exec_tmr #(
   parameter int unsigned EXEC_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic accept_o,
   output logic busy_o,
   output logic done_o
);
   localparam int unsigned CW    = $clog2(EXEC_CYC + 1);
   localparam logic [CW-1:0] LOADV = CW'(EXEC_CYC);

   generate
      if (EXEC_CYC < 1) begin : g_bad_cyc
         $error("rps_exec_tmr: EXEC_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign busy_o   = (cnt_q != '0);
   assign accept_o = start_i && !busy_o;
   assign done_o   = (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (accept_o) cnt_q <= LOADV;
      else if (busy_o)   cnt_q <= cnt_q - CW'(1);
   end
endmodule

// File: rtl/rps_trig_bank.sv
module rps_trig_bank #(
   parameter int unsigned NT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [NT-1:0] val_i,
   input  logic          clr_i,
   output logic [NT-1:0] q_o
);
   generate
      if (NT < 1) begin : g_bad_nt
         $error("rps_trig_bank: NT must be at least 1");
      end
      for (genvar g = 0; g < NT; g++) begin : g_trig
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bit_q <= 1'b0;
            else if (load_i) bit_q <= val_i[g];
            else if (clr_i)  bit_q <= 1'b0;
         end
         assign q_o[g] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/rps_remote_seq.sv
module rps_remote_seq
   import rps_pkg::*;
#(
   parameter int unsigned AW        = 15,
   parameter int unsigned XFER_ADDR = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          halt_req_i,
   input  logic [1:0]    cause_i,
   input  logic [AW-1:0] loc_i,
   input  logic [AW-1:0] field_i,
   input  logic          auto_i,
   input  logic          start_trg_i,
   input  logic          skip_trg_i,
   input  logic          xfer_trg_i,
   output logic [AW-1:0] pc_o,
   output logic          halted_o,
   output logic          running_o,
   output logic          icycle_o
);
   localparam logic [AW-1:0] XFER_A = AW'(XFER_ADDR);

   generate
      if (AW < 2 || AW > 32) begin : g_bad_aw
         $error("rps_remote_seq: AW out of range");
      end
      if (XFER_ADDR >= (64'd1 << AW)) begin : g_bad_xa
         $error("rps_remote_seq: XFER_ADDR does not fit in AW bits");
      end
   endgenerate

   rstate_e       st_q;
   halt_cause_e   cause_q;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] field_q;
   logic [AW-1:0] resume_pc;

   always_comb begin
      if (xfer_trg_i)                resume_pc = XFER_A;
      else if (cause_q == CAUSE_HTR) resume_pc = field_q;
      else if (skip_trg_i)           resume_pc = pc_q + AW'(2);
      else                           resume_pc = pc_q + AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RS_HALT;
         cause_q <= CAUSE_PLAIN;
         pc_q    <= '0;
         field_q <= '0;
      end else begin
         case (st_q)
            RS_RUN: begin
               if (halt_req_i) begin
                  st_q    <= RS_HALT;
                  pc_q    <= loc_i;
                  field_q <= field_i;
                  cause_q <= halt_cause_e'(cause_i);
               end
            end
            RS_HALT: begin
               if (start_trg_i && auto_i) st_q <= RS_RESTART;
            end
            RS_RESTART: begin
               pc_q <= resume_pc;
               st_q <= RS_ICYC;
            end
            default: begin
               st_q <= RS_RUN;
            end
         endcase
      end
   end

   assign pc_o      = pc_q;
   assign halted_o  = (st_q == RS_HALT);
   assign running_o = (st_q == RS_RUN);
   assign icycle_o  = (st_q == RS_ICYC);
endmodule

// File: rtl/rps_top.sv
module rps_top
   import rps_pkg::*;
#(
   parameter int unsigned AW        = 15,
   parameter int unsigned OPW       = 3,
   parameter int unsigned SKIP_BIT  = 0,
   parameter int unsigned XFER_BIT  = 1,
   parameter int unsigned TRAP_BIT  = 2,
   parameter int unsigned EXEC_CYC  = 3,
   parameter int unsigned XFER_ADDR = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [OPW-1:0] opnd_i,
   input  logic           mp_mode_i,
   input  logic           halt_req_i,
   input  logic [1:0]     halt_cause_i,
   input  logic [AW-1:0]  halt_loc_i,
   input  logic [AW-1:0]  halt_field_i,
   input  logic           auto_i,
   input  logic           remote_icyc_i,
   output logic           busy_o,
   output logic           done_o,
   output logic           start_trg_o,
   output logic           skip_trg_o,
   output logic           xfer_trg_o,
   output logic           trap_en_o,
   output logic           halted_o,
   output logic           running_o,
   output logic           icycle_o,
   output logic [AW-1:0]  pc_o
);
   logic             accept;
   logic             load;
   logic             q_skip;
   logic             q_xfer;
   logic             q_trap;
   logic [NTRIG-1:0] trig_val;
   logic [NTRIG-1:0] trig_q;
   logic             trap_q;

   rps_opdec #(
      .OPW(OPW), .SKIP_BIT(SKIP_BIT), .XFER_BIT(XFER_BIT), .TRAP_BIT(TRAP_BIT)
   ) u_dec (
      .opnd_i(opnd_i), .skip_o(q_skip), .xfer_o(q_xfer), .trap_o(q_trap)
   );

   rps_exec_tmr #(.EXEC_CYC(EXEC_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .accept_o(accept), .busy_o(busy_o), .done_o(done_o)
   );

   assign load = accept && mp_mode_i;

   always_comb begin
      trig_val           = '0;
      trig_val[TG_START] = 1'b1;
      trig_val[TG_SKIP]  = q_skip;
      trig_val[TG_XFER]  = q_xfer;
   end

   rps_trig_bank #(.NT(NTRIG)) u_trig (
      .clk(clk), .rst_n(rst_n), .load_i(load), .val_i(trig_val),
      .clr_i(icycle_o || remote_icyc_i), .q_o(trig_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                trap_q <= 1'b0;
      else if (load && q_trap)   trap_q <= 1'b1;
   end

   rps_remote_seq #(.AW(AW), .XFER_ADDR(XFER_ADDR)) u_rem (
      .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req_i), .cause_i(halt_cause_i),
      .loc_i(halt_loc_i), .field_i(halt_field_i), .auto_i(auto_i),
      .start_trg_i(trig_q[TG_START]), .skip_trg_i(trig_q[TG_SKIP]),
      .xfer_trg_i(trig_q[TG_XFER]), .pc_o(pc_o), .halted_o(halted_o),
      .running_o(running_o), .icycle_o(icycle_o)
   );

   assign start_trg_o = trig_q[TG_START];
   assign skip_trg_o  = trig_q[TG_SKIP];
   assign xfer_trg_o  = trig_q[TG_XFER];
   assign trap_en_o   = trap_q;
endmodule

// File: rtl/rps_chk.sv
module rps_chk #(
   parameter int unsigned AW = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          mp_mode_i,
   input logic          halt_req_i,
   input logic          auto_i,
   input logic          remote_icyc_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          start_trg_o,
   input logic          skip_trg_o,
   input logic          xfer_trg_o,
   input logic          trap_en_o,
   input logic          halted_o,
   input logic          running_o,
   input logic          icycle_o,
   input logic [AW-1:0] pc_o
);
   // R2
   no_start_outside_mp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !mp_mode_i && !start_trg_o) |=> !start_trg_o);

   // R2
   no_trap_outside_mp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !mp_mode_i && !trap_en_o) |=> !trap_en_o);

   // R11
   busy_ends_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   // R11
   accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R8
   icycle_clears_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (icycle_o && !(start_i && !busy_o && mp_mode_i)) |=>
         (!start_trg_o && !skip_trg_o && !xfer_trg_o));

   // R9
   manual_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && !auto_i) |=> (halted_o && $stable(pc_o)));

   // R10
   running_pc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && !halt_req_i) |=> (running_o && $stable(pc_o)));

   // R7
   icycle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      icycle_o |=> (running_o && !icycle_o));

   // R12
   trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_en_o |=> trap_en_o);
endmodule

bind rps_top rps_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .mp_mode_i(mp_mode_i),
   .halt_req_i(halt_req_i), .auto_i(auto_i), .remote_icyc_i(remote_icyc_i),
   .busy_o(busy_o), .done_o(done_o), .start_trg_o(start_trg_o),
   .skip_trg_o(skip_trg_o), .xfer_trg_o(xfer_trg_o), .trap_en_o(trap_en_o),
   .halted_o(halted_o), .running_o(running_o), .icycle_o(icycle_o), .pc_o(pc_o)
);

// File: tb/rps_top_tb_top.sv
`timescale 1ns/1ps
module rps_top_tb_top;
   localparam int AW   = 15;
   localparam int XFER = 4;

   typedef struct packed {
      logic [1:0]  cause;
      logic [2:0]  op;
      logic [14:0] loc;
      logic [14:0] fld;
      logic [14:0] exp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VT [NV] = '{
      '{2'd0, 3'd0, 15'd100,    15'd777,  15'd101},   // R4 plain
      '{2'd0, 3'd1, 15'd200,    15'd777,  15'd202},   // R5 plain+skip
      '{2'd1, 3'd0, 15'd300,    15'd1234, 15'd1234},  // R4 halt-and-transfer
      '{2'd1, 3'd1, 15'd310,    15'd50,   15'd50},    // R5 skip dropped
      '{2'd2, 3'd0, 15'd400,    15'd9,    15'd401},   // R4 divide-check
      '{2'd2, 3'd1, 15'd410,    15'd9,    15'd412},   // R5 divide+skip
      '{2'd0, 3'd2, 15'd500,    15'd9,    15'd4},     // R6 transfer
      '{2'd0, 3'd3, 15'd510,    15'd9,    15'd4},     // R6 transfer over skip
      '{2'd1, 3'd2, 15'd520,    15'd60,   15'd4},     // R6 transfer over cause
      '{2'd0, 3'd1, 15'h7FFF,   15'd9,    15'd1},     // R5 wrap
      '{2'd0, 3'd0, 15'h7FFF,   15'd9,    15'd0},     // R4 wrap
      '{2'd3, 3'd0, 15'd20,     15'd9,    15'd21},    // R4 reserved code
      '{2'd2, 3'd4, 15'd30,     15'd9,    15'd31}     // R3 trap bit only
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    opnd_i = '0;
   logic          mp_mode_i = 1'b1;
   logic          halt_req_i = 1'b0;
   logic [1:0]    halt_cause_i = '0;
   logic [AW-1:0] halt_loc_i = '0;
   logic [AW-1:0] halt_field_i = '0;
   logic          auto_i = 1'b1;
   logic          remote_icyc_i = 1'b0;
   logic          busy_o, done_o, start_trg_o, skip_trg_o, xfer_trg_o, trap_en_o;
   logic          halted_o, running_o, icycle_o;
   logic [AW-1:0] pc_o;

   int nchk = 0;
   int nerr = 0;
   bit fin  = 1'b0;

   always #2 clk = ~clk;

   rps_top dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .opnd_i(opnd_i),
      .mp_mode_i(mp_mode_i), .halt_req_i(halt_req_i), .halt_cause_i(halt_cause_i),
      .halt_loc_i(halt_loc_i), .halt_field_i(halt_field_i), .auto_i(auto_i),
      .remote_icyc_i(remote_icyc_i), .busy_o(busy_o), .done_o(done_o),
      .start_trg_o(start_trg_o), .skip_trg_o(skip_trg_o), .xfer_trg_o(xfer_trg_o),
      .trap_en_o(trap_en_o), .halted_o(halted_o), .running_o(running_o),
      .icycle_o(icycle_o), .pc_o(pc_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_halt(input logic [1:0] c, input logic [AW-1:0] l,
                          input logic [AW-1:0] f);
      @(negedge clk);
      halt_req_i = 1'b1; halt_cause_i = c; halt_loc_i = l; halt_field_i = f;
      @(negedge clk);
      halt_req_i = 1'b0;
   endtask

   task automatic do_start(input logic [2:0] op);
      @(negedge clk);
      start_i = 1'b1; opnd_i = op;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!fin) begin
         nerr++;
         $display("FAIL R7 watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "halted", 32'(halted_o), 1);
      chk("R1", "pc", 32'(pc_o), 0);
      chk("R1", "busy/done", {30'd0, busy_o, done_o}, 0);
      chk("R1", "triggers", {29'd0, start_trg_o, skip_trg_o, xfer_trg_o}, 0);
      chk("R1", "trap/run/icyc", {29'd0, trap_en_o, running_o, icycle_o}, 0);
      rst_n = 1'b1;

      // R7 + R11 cycle-by-cycle restart from reset halt
      do_start(3'd0);
      chk("R7", "still halted after E0", 32'(halted_o), 1);
      chk("R11", "busy after E0", {30'd0, busy_o, done_o}, 32'b10);
      chk("R3", "start trigger set", 32'(start_trg_o), 1);
      @(negedge clk);
      chk("R7", "master stop cleared after E1", {30'd0, halted_o, icycle_o}, 0);
      chk("R7", "pc held after E1", 32'(pc_o), 0);
      @(negedge clk);
      chk("R7", "icycle after E2", 32'(icycle_o), 1);
      chk("R7", "pc after E2", 32'(pc_o), 1);
      chk("R11", "done after E2", {30'd0, busy_o, done_o}, 32'b11);
      @(negedge clk);
      chk("R7", "running after E3", {30'd0, running_o, icycle_o}, 32'b10);
      chk("R8", "triggers cleared", {29'd0, start_trg_o, skip_trg_o, xfer_trg_o}, 0);
      chk("R11", "busy over", 32'(busy_o), 0);

      // R2 start outside multiprocess mode
      do_halt(2'd0, 15'd77, 15'd5);
      mp_mode_i = 1'b0;
      do_start(3'b111);
      chk("R11", "busy without mp", 32'(busy_o), 1);
      repeat (4) @(negedge clk);
      chk("R2", "no triggers", {29'd0, start_trg_o, skip_trg_o, xfer_trg_o}, 0);
      chk("R2", "no trap enable", 32'(trap_en_o), 0);
      chk("R2", "remote halted, pc kept", {16'd0, halted_o, pc_o}, {16'd0, 1'b1, 15'd77});
      mp_mode_i = 1'b1;
      do_start(3'd0);
      repeat (3) @(negedge clk);
      chk("R4", "resume after mp restored", 32'(pc_o), 78);

      // R10 start to a running remote, R8 clear by remote signal
      do_start(3'b101);
      chk("R10", "trap enabled on running", 32'(trap_en_o), 1);
      repeat (4) @(negedge clk);
      chk("R10", "pc unchanged", 32'(pc_o), 78);
      chk("R10", "still running", 32'(running_o), 1);
      chk("R8", "triggers held until icycle", {30'd0, start_trg_o, skip_trg_o}, 32'b11);
      remote_icyc_i = 1'b1;
      @(negedge clk);
      remote_icyc_i = 1'b0;
      chk("R8", "cleared by remote icycle", {29'd0, start_trg_o, skip_trg_o, xfer_trg_o}, 0);

      // Vector table: R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         do_halt(VT[i].cause, VT[i].loc, VT[i].fld);
         chk("R4", "halted before start", 32'(halted_o), 1);
         do_start(VT[i].op);
         repeat (3) @(negedge clk);
         chk("R4/R5/R6", $sformatf("vector %0d resume pc", i), 32'(pc_o), 32'(VT[i].exp));
         chk("R7", $sformatf("vector %0d running", i), 32'(running_o), 1);
      end
      chk("R12", "trap enable sticky", 32'(trap_en_o), 1);

      // R9 manual switch
      do_halt(2'd0, 15'd40, 15'd3);
      auto_i = 1'b0;
      do_start(3'b001);
      repeat (5) @(negedge clk);
      chk("R9", "held in manual", {16'd0, halted_o, pc_o}, {16'd0, 1'b1, 15'd40});
      chk("R9", "triggers kept", {30'd0, start_trg_o, skip_trg_o}, 32'b11);
      auto_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9", "restart after auto", {16'd0, running_o, pc_o}, {16'd0, 1'b1, 15'd42});

      // R11 second strobe while busy is ignored
      do_halt(2'd0, 15'd50, 15'd3);
      @(negedge clk);
      start_i = 1'b1; opnd_i = 3'b000;
      @(negedge clk);
      opnd_i = 3'b010;
      @(negedge clk);
      start_i = 1'b0;
      chk("R11", "busy strobe ignored (no transfer)", 32'(xfer_trg_o), 0);
      repeat (2) @(negedge clk);
      chk("R11", "resume unaffected by ignored strobe", 32'(pc_o), 51);

      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule